// File: doc/BRIEF.md
# Phase-Shifted Three-Level Half-Bridge Gate Generator

This block drives the eight switches of two neutral-point-clamped three-level half-bridge legs, called leg A and leg B. Each leg has two inner switches and two outer switches. One free-running counter produces two timing signals. The first is a 50% square reference with the full switching period. The second is a sawtooth carrier with half that period, and it restarts on every edge of the square.

The inner switches follow the square directly. Each outer switch is the same square delayed by a number of cycles. That delay is proportional to a 16-bit modulation fraction: `mod_xy` sets the delay for leg A and `mod_yz` sets it for leg B. The result is that each leg applies a positive, zero or negative voltage to its transformer primary. In every half period the two legs apply pulses of opposite sign.

Every complementary pair of switches passes through an on-delay stage. When a gate turns off, its partner stays off for the programmed dead time before it turns on. The switching period and the dead time are both parameters, counted in clock cycles.

Top module: `npc_pshift_gate`

## Requirements
- R1: While `en` is low, or in the cycle after `en` is first seen low, all eight gate outputs are 0. Reset also forces them to 0.
- R2: The two gates of a complementary pair are never both 1. The four pairs are (a_inner_top, a_inner_bot), (a_outer_top, a_outer_bot), (b_inner_top, b_inner_bot) and (b_outer_top, b_outer_bot).
- R3: A gate turns on only after its partner has been off for DEAD_CYC consecutive cycles. An inner gate is therefore high for HALF−DEAD_CYC cycles in every period, where HALF = PERIOD_CYC/2.
- R4: The counter runs from 0 to PERIOD_CYC−1 and wraps. The square reference is 1 in the first half of the period. The carrier equals the counter modulo HALF.
- R5: The delay is s = min(floor(word·HALF/65536), HALF−DEAD_CYC). Leg A is positive (a_outer_top and a_inner_top both 1) for max(s−DEAD_CYC, 0) cycles per period. Leg A is negative (a_inner_bot and a_outer_bot both 1) for the same number of cycles.
- R6: Leg B uses `mod_yz` in the same way. Its positive state (b_outer_top and b_inner_top) and its negative state (b_inner_bot and b_outer_bot) each last max(s−DEAD_CYC, 0) cycles per period.
- R7: The two legs are never positive in the same cycle, and they are never negative in the same cycle.
- R8: A modulation word is captured only in the last cycle before each carrier period starts, and also while disabled. A change in the middle of a half period has no effect until the next half period.
- R9: Once `en` is seen high after being low, the counter starts again from 0. a_inner_top rises exactly DEAD_CYC+1 clock edges after the first edge that sees `en` high.
- R10: A full-scale word is clamped to a delay of HALF−DEAD_CYC. The pulse is then HALF−2·DEAD_CYC cycles wide, never wider.
- R11: Each outer gate is high for HALF−DEAD_CYC cycles per period while its word is held constant. a_inner_top always equals b_inner_bot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low forces all gates off and holds the counter at 0 |
| mod_xy | input | MOD_W | Leg A modulation fraction (0 to nearly 1) |
| mod_yz | input | MOD_W | Leg B modulation fraction |
| a_outer_top | output | 1 | Leg A upper outer switch gate |
| a_inner_top | output | 1 | Leg A upper inner switch gate |
| a_inner_bot | output | 1 | Leg A lower inner switch gate |
| a_outer_bot | output | 1 | Leg A lower outer switch gate |
| b_outer_top | output | 1 | Leg B upper outer switch gate |
| b_inner_top | output | 1 | Leg B upper inner switch gate |
| b_inner_bot | output | 1 | Leg B lower inner switch gate |
| b_outer_bot | output | 1 | Leg B lower outer switch gate |

## Verification
A disable request and the end of a dead-time interval can fall in the same cycle. In that cycle the on-delay stage is about to turn a gate on while the enable logic is forcing every gate low.

The bench restarts the block and counts exactly DEAD_CYC edges. It then drops `en` so that the disable lands on the edge where a_inner_top would have risen. The check passes only if all eight gates stay at 0 on that edge and afterwards.

A second overlap is a word change in the middle of a half period while a pulse is running. Pulse widths are counted over that half period and over a later period, and compared against the old and the new word.

// File: rtl/npg_pkg.sv
package npg_pkg;

  // Largest delay that still leaves one full dead time before the next edge
  // of the square reference.
  function automatic int unsigned shift_limit(input int unsigned half_cyc,
                                              input int unsigned dead_cyc);
    return half_cyc - dead_cyc;
  endfunction

  // Width of a counter that must hold values 0..n.
  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/npg_timer.sv
module npg_timer #(
  parameter int unsigned PERIOD_CYC = 10000,
  parameter int unsigned CW         = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic [CW-1:0] cnt,
  output logic          first_half,
  output logic [CW-1:0] carrier,
  output logic          load
);
  localparam int unsigned HALF = PERIOD_CYC / 2;
  localparam logic [CW-1:0] LAST   = CW'(PERIOD_CYC - 1);
  localparam logic [CW-1:0] HALF_V = CW'(HALF);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    first_half = (cnt < HALF_V);
    carrier    = first_half ? cnt : (cnt - HALF_V);
    // Capture the words on the cycle before a carrier period begins, or at
    // any time the block is disabled (the counter restarts at 0).
    load       = !en || (cnt == HALF_V - 1'b1) || (cnt == LAST);
  end

  // R4: the counter never leaves its range.
  a_r4_cnt_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

  // R9: a cycle spent disabled leaves the counter at zero.
  a_r9_restart_zero: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> (cnt == '0));

endmodule

// File: rtl/npg_shift.sv
module npg_shift #(
  parameter int unsigned MOD_W    = 16,
  parameter int unsigned HALF     = 5000,
  parameter int unsigned DEAD_CYC = 120,
  parameter int unsigned CW       = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [MOD_W-1:0] word,
  output logic [CW-1:0]    shift_q
);
  import npg_pkg::*;

  localparam int unsigned PW = MOD_W + CW;
  localparam logic [CW-1:0] LIMIT = CW'(shift_limit(HALF, DEAD_CYC));

  logic [PW-1:0] prod;
  logic [CW-1:0] scaled;
  logic [CW-1:0] clamped;

  always_comb begin
    prod    = PW'(word) * PW'(HALF);
    scaled  = prod[MOD_W +: CW];
    clamped = (scaled > LIMIT) ? LIMIT : scaled;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= '0;
    end else if (load) begin
      shift_q <= clamped;
    end
  end

  // R10: the applied delay never goes past half a period minus the dead time.
  a_r10_clamp: assert property (@(posedge clk) disable iff (rst)
    shift_q <= LIMIT);

  // R8: between carrier boundaries the applied delay stays fixed.
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(load) |-> $stable(shift_q));

endmodule

// File: rtl/npg_deadband.sv
module npg_deadband #(
  parameter int unsigned DEAD_CYC = 120,
  parameter int unsigned AW       = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic raw,
  output logic on_q,
  output logic off_q
);
  localparam logic [AW-1:0] DEAD_V = AW'(DEAD_CYC);

  logic          level_q;
  logic [AW-1:0] age_q;
  logic          level_n;
  logic [AW-1:0] age_n;

  always_comb begin
    level_n = raw;
    if (raw != level_q) begin
      age_n = '0;
    end else if (age_q < DEAD_V) begin
      age_n = age_q + 1'b1;
    end else begin
      age_n = age_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      level_q <= 1'b0;
      age_q   <= '0;
      on_q    <= 1'b0;
      off_q   <= 1'b0;
    end else begin
      level_q <= level_n;
      age_q   <= age_n;
      on_q    <= level_n  && (age_n == DEAD_V);
      off_q   <= !level_n && (age_n == DEAD_V);
    end
  end

  // R1: disabling forces both gates low on the next edge.
  a_r1_disable_low: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> (!on_q && !off_q));

  generate
    if (DEAD_CYC > 0) begin : g_gap
      // R3: a gate never turns on in the cycle its partner turns off.
      a_r3_gap_on: assert property (@(posedge clk) disable iff (rst)
        $rose(on_q) |-> !$past(off_q));
      a_r3_gap_off: assert property (@(posedge clk) disable iff (rst)
        $rose(off_q) |-> !$past(on_q));
    end
  endgenerate

endmodule

// File: rtl/npc_pshift_gate.sv
module npc_pshift_gate #(
  parameter int unsigned PERIOD_CYC = 10000,
  parameter int unsigned DEAD_CYC   = 120,
  parameter int unsigned MOD_W      = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [MOD_W-1:0] mod_xy,
  input  logic [MOD_W-1:0] mod_yz,
  output logic             a_outer_top,
  output logic             a_inner_top,
  output logic             a_inner_bot,
  output logic             a_outer_bot,
  output logic             b_outer_top,
  output logic             b_inner_top,
  output logic             b_inner_bot,
  output logic             b_outer_bot
);
  import npg_pkg::*;

  localparam int unsigned HALF  = PERIOD_CYC / 2;
  localparam int unsigned CW    = cnt_bits(PERIOD_CYC);
  localparam int unsigned AW    = cnt_bits(DEAD_CYC);
  localparam int unsigned NLEG  = 2;
  localparam int unsigned NPAIR = 4;

  logic [CW-1:0] cnt;
  logic          first_half;
  logic [CW-1:0] carrier;
  logic          load;

  npg_timer #(.PERIOD_CYC(PERIOD_CYC), .CW(CW)) timer_i (
    .clk(clk), .rst(rst), .en(en),
    .cnt(cnt), .first_half(first_half), .carrier(carrier), .load(load)
  );

  logic [MOD_W-1:0] words [NLEG];
  logic [CW-1:0]    shifts [NLEG];
  logic [NLEG-1:0]  outer_raw;

  assign words[0] = mod_xy;
  assign words[1] = mod_yz;

  // Each outer reference is the square delayed by the leg's shift. Written
  // as a compare against the carrier: in the first half it is high once the
  // carrier reaches the shift, and in the second half it is high until then.
  generate
    for (genvar g = 0; g < NLEG; g++) begin : g_leg
      npg_shift #(.MOD_W(MOD_W), .HALF(HALF), .DEAD_CYC(DEAD_CYC), .CW(CW)) shift_i (
        .clk(clk), .rst(rst), .load(load), .word(words[g]), .shift_q(shifts[g])
      );
      assign outer_raw[g] = first_half ? (carrier >= shifts[g]) : (carrier < shifts[g]);
    end
  endgenerate

  // Pair raw levels: 0 = leg A inner, 1 = leg A outer,
  // 2 = leg B inner, 3 = leg B outer.
  logic [NPAIR-1:0] pair_raw;
  logic [NPAIR-1:0] pair_on;
  logic [NPAIR-1:0] pair_off;

  assign pair_raw = {outer_raw[1], first_half, outer_raw[0], first_half};

  generate
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      npg_deadband #(.DEAD_CYC(DEAD_CYC), .AW(AW)) band_i (
        .clk(clk), .rst(rst), .en(en), .raw(pair_raw[p]),
        .on_q(pair_on[p]), .off_q(pair_off[p])
      );
    end
  endgenerate

  // Leg A: the square drives the upper inner gate; the delayed square drives
  // the lower outer gate. Leg B is mirrored: the square drives the lower
  // inner gate and the delayed square drives the upper outer gate.
  assign a_inner_top = pair_on[0];
  assign a_inner_bot = pair_off[0];
  assign a_outer_bot = pair_on[1];
  assign a_outer_top = pair_off[1];
  assign b_inner_bot = pair_on[2];
  assign b_inner_top = pair_off[2];
  assign b_outer_top = pair_on[3];
  assign b_outer_bot = pair_off[3];

  logic a_pos, a_neg, b_pos, b_neg;
  assign a_pos = a_outer_top && a_inner_top;
  assign a_neg = a_inner_bot && a_outer_bot;
  assign b_pos = b_outer_top && b_inner_top;
  assign b_neg = b_inner_bot && b_outer_bot;

  // R7: the two primaries never carry the same nonzero polarity.
  a_r7_polarity: assert property (@(posedge clk) disable iff (rst)
    !(a_pos && b_pos) && !(a_neg && b_neg));

  // R11: both legs share one square reference.
  a_r11_inner_shared: assert property (@(posedge clk) disable iff (rst)
    a_inner_top == b_inner_bot);

  // R2: no leg ever shorts its outer pair.
  a_r2_outer_excl: assert property (@(posedge clk) disable iff (rst)
    !(a_outer_top && a_outer_bot) && !(b_outer_top && b_outer_bot));

endmodule

// File: tb/npc_pshift_gate_tb_top.sv
`timescale 1ns/1ps
module npc_pshift_gate_tb_top;
  localparam int P = 40;
  localparam int D = 3;
  localparam int H = P / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [15:0] mod_xy = '0;
  logic [15:0] mod_yz = '0;
  logic a_ot, a_it, a_ib, a_ob, b_ot, b_it, b_ib, b_ob;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  npc_pshift_gate #(.PERIOD_CYC(P), .DEAD_CYC(D), .MOD_W(16)) dut_i (
    .clk(clk), .rst(rst), .en(en), .mod_xy(mod_xy), .mod_yz(mod_yz),
    .a_outer_top(a_ot), .a_inner_top(a_it), .a_inner_bot(a_ib), .a_outer_bot(a_ob),
    .b_outer_top(b_ot), .b_inner_top(b_it), .b_inner_bot(b_ib), .b_outer_bot(b_ob)
  );

  // Vector: mxy, myz, expected leg A pulse width, expected leg B pulse width.
  // Widths follow R5/R6/R10 with HALF=20, dead time 3.
  typedef struct packed {
    logic [15:0] mxy;
    logic [15:0] myz;
    logic [7:0]  wa;
    logic [7:0]  wb;
  } vec_t;
  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{16'h0000, 16'h0000, 8'd0,  8'd0},
    '{16'h8000, 16'h4000, 8'd7,  8'd2},
    '{16'hFFFF, 16'h2000, 8'd14, 8'd0},
    '{16'h6000, 16'hE000, 8'd4,  8'd14},
    '{16'h4CCD, 16'h9999, 8'd3,  8'd8}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  function automatic int all_gates();
    return {a_ot, a_it, a_ib, a_ob, b_ot, b_it, b_ib, b_ob};
  endfunction

  int n_apos, n_aneg, n_bpos, n_bneg, n_ait, n_aob, n_ovl, n_pol, n_shr;

  task automatic measure();
    n_apos = 0; n_aneg = 0; n_bpos = 0; n_bneg = 0;
    n_ait = 0; n_aob = 0; n_ovl = 0; n_pol = 0; n_shr = 0;
    for (int k = 0; k < P; k++) begin
      tick();
      if (a_ot && a_it) n_apos++;
      if (a_ib && a_ob) n_aneg++;
      if (b_ot && b_it) n_bpos++;
      if (b_ib && b_ob) n_bneg++;
      if (a_it) n_ait++;
      if (a_ob) n_aob++;
      if ((a_it && a_ib) || (a_ot && a_ob) || (b_it && b_ib) || (b_ot && b_ob)) n_ovl++;
      if ((a_ot && a_it && b_ot && b_it) || (a_ib && a_ob && b_ib && b_ob)) n_pol++;
      if (a_it != b_ib) n_shr++;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int cnt_old;
    // R1: reset state
    repeat (3) tick();
    check(all_gates() == 0, "R1 reset gates", all_gates(), 0);
    rst = 1'b0;
    tick();
    check(all_gates() == 0, "R1 disabled gates", all_gates(), 0);

    // R9: restart timing; next edge is the first that sees en high
    en = 1'b1;
    repeat (D) tick();
    check(a_it == 1'b0, "R9 inner before dead time", a_it, 0);
    tick();
    check(a_it == 1'b1, "R9 inner after dead time", a_it, 1);

    // Vector table: R2 R3 R5 R6 R7 R10 R11
    for (int v = 0; v < NV; v++) begin
      mod_xy = VECS[v].mxy;
      mod_yz = VECS[v].myz;
      repeat (2 * P) tick();
      measure();
      check(n_apos == int'(VECS[v].wa), "R5 leg A positive width", n_apos, VECS[v].wa);
      check(n_aneg == int'(VECS[v].wa), "R5 leg A negative width", n_aneg, VECS[v].wa);
      check(n_bpos == int'(VECS[v].wb), "R6 leg B positive width", n_bpos, VECS[v].wb);
      check(n_bneg == int'(VECS[v].wb), "R6 leg B negative width", n_bneg, VECS[v].wb);
      check(n_ait == H - D, "R3 inner high per period", n_ait, H - D);
      check(n_aob == H - D, "R11 outer high per period", n_aob, H - D);
      check(n_ovl == 0, "R2 pair overlap", n_ovl, 0);
      check(n_pol == 0, "R7 same polarity", n_pol, 0);
      check(n_shr == 0, "R11 shared square", n_shr, 0);
    end
    // R10: full scale is vector 2, width HALF-2*D
    check(int'(VECS[2].wa) == H - 2 * D, "R10 clamp table entry", VECS[2].wa, H - 2 * D);

    // R8: mid-half word change is deferred
    mod_xy = 16'h4000;
    en = 1'b0;
    tick();
    en = 1'b1;
    repeat (P) tick();
    cnt_old = 0;
    for (int j = 0; j < H; j++) begin
      tick();
      if (a_ot && a_it) cnt_old++;
      if (j == 10) mod_xy = 16'hC000;
    end
    check(cnt_old == 2, "R8 half with old word", cnt_old, 2);
    repeat (2 * P) tick();
    measure();
    check(n_apos == 12, "R8 new word applied", n_apos, 12);

    // R1 with R3: disable lands on the edge a dead time would expire
    en = 1'b0;
    tick();
    check(all_gates() == 0, "R1 disable next edge", all_gates(), 0);
    en = 1'b1;
    repeat (D) tick();
    en = 1'b0;
    tick();
    check(all_gates() == 0, "R1 disable at dead expiry", all_gates(), 0);
    repeat (5) tick();
    check(all_gates() == 0, "R1 held off", all_gates(), 0);

    // R4/R9: restart again and confirm the square is phase-aligned to enable
    en = 1'b1;
    repeat (D + 1) tick();
    cnt_old = 0;
    for (int j = 0; j < H; j++) begin
      if (a_it) cnt_old++;
      tick();
    end
    check(cnt_old == H - D, "R4 first half after restart", cnt_old, H - D);

    finish_run();
  end
endmodule